// File: doc/BRIEF.md
# Linear Ratio Video Line Decimator

This block shrinks one video field in real time. It takes active-line pixels from a stream with a valid strobe. Line-start and field-start markers delimit the stream. The block keeps a linear subset of pixels and lines. The horizontal ratio is a numerator over a fixed denominator of 96. The vertical ratio is a separate numerator over the same denominator. A phase accumulator spreads the kept samples evenly across the line, and spreads the kept lines evenly across the field.

After decimation, each kept pixel can be emitted once, twice or four times in a row. The input is held off while the copies go out. Each kept line carries a flag that tells the downstream store to show that line twice. Ratios and expansion settings are captured only at a field start, so a field is always processed with one consistent setting.

Top module: `line_ratio_decimator`

## Requirements
- R1: After reset, `out_valid` and `out_line_valid` are 0 and `in_ready` is 1. No pixel or line is reported until the first `field_start` has captured a setting.
- R2: With horizontal numerator Hk, a line of N accepted pixels yields floor(N·Hk/96) output pixels (before expansion). A pixel is kept when adding Hk to the horizontal accumulator reaches 96 or more; 96 is then subtracted. Examples: 1408 pixels give 704 at Hk=48, 352 at Hk=24 and 14 at Hk=1.
- R3: With vertical numerator Vk, L lines in a field yield floor(L·Vk/96) kept lines, chosen by the same accumulator rule applied once per line start. `out_line_valid` is 1 for a kept line from the cycle after its line start. Example: 228 lines at Vk=48 keep 114.
- R4: A captured numerator of 0, horizontal or vertical, produces no output pixels for the whole field.
- R5: Numerators above their maximum are clamped: Hk above 48 acts as 48, and Vk above 96 acts as 96.
- R6: The numerators and expansion codes are sampled only in a `field_start` cycle. A change at any other time has no effect until the next field start.
- R7: The horizontal expansion code `hexp_cfg` gives the copies per kept pixel: 2'b00 gives 1, 2'b01 gives 2 and 2'b11 gives 4. The value 2'b10 acts as 1. While copies remain, `in_ready` is 0, and `out_data` holds its value with `out_valid` at 1.
- R8: `out_line_rep` is 1 exactly for kept lines of a field whose captured `vexp_cfg` is 1.
- R9: A line start (or field start) restarts the horizontal accumulator at 0. A field start restarts the vertical accumulator at 0. The keep pattern therefore repeats identically in each line and in each field.
- R10: A kept pixel accepted at a clock edge appears on `out_data` with `out_valid` in the following cycle. Pixels come out in input order, and no pixel appears without an accepted input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hk_cfg | input | 6 | Horizontal numerator (0..48, larger values clamp) |
| vk_cfg | input | 7 | Vertical numerator (0..96, larger values clamp) |
| hexp_cfg | input | 2 | Horizontal pixel copy code |
| vexp_cfg | input | 1 | Vertical line doubling request |
| line_start | input | 1 | One-cycle pulse starting a line |
| field_start | input | 1 | One-cycle pulse starting a field (also starts a line) |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | 8 | Input pixel value |
| in_ready | output | 1 | Input pixel accepted when high with `in_valid` |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 8 | Output pixel value |
| out_line_valid | output | 1 | Current line is kept |
| out_line_rep | output | 1 | Current kept line is to be shown twice |

## Verification
The bench uses the default parameters: 8-bit pixels, the fixed denominator of 96, and limits of 48 and 96. These settings make the nominal counts directly checkable: full 1408-sample lines produce 704, 352 and 14 outputs, and 228-line fields produce 114 and 76 kept lines. The 6-bit and 7-bit numerator widths let the bench drive values above the limits to exercise clamping. Short three-pixel lines and three-line fields show that the keep position returns to the same place after each restart.

// File: rtl/lrd_pkg.sv
package lrd_pkg;

    localparam int unsigned RATIO_DEN   = 96;
    localparam int unsigned H_NUM_BITS  = 6;
    localparam int unsigned V_NUM_BITS  = 7;
    localparam int unsigned H_NUM_LIMIT = 48;
    localparam int unsigned V_NUM_LIMIT = 96;
    localparam int unsigned REP_BITS    = 3;

    typedef enum logic [1:0] {
        HEXP_X1  = 2'b00,
        HEXP_X2  = 2'b01,
        HEXP_RSV = 2'b10,
        HEXP_X4  = 2'b11
    } hexp_e;

    typedef struct packed {
        hexp_e hexp;
        logic  vexp;
    } expand_t;

    function automatic logic [REP_BITS-1:0] rep_count(input hexp_e code);
        case (code)
            HEXP_X2: rep_count = 3'd2;
            HEXP_X4: rep_count = 3'd4;
            default: rep_count = 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/lrd_cfg_hold.sv
module lrd_cfg_hold
    import lrd_pkg::*;
#(
    parameter int unsigned H_NUM_W = H_NUM_BITS,
    parameter int unsigned V_NUM_W = V_NUM_BITS,
    parameter int unsigned H_MAX   = H_NUM_LIMIT,
    parameter int unsigned V_MAX   = V_NUM_LIMIT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [H_NUM_W-1:0] h_in,
    input  logic [V_NUM_W-1:0] v_in,
    input  expand_t            exp_in,
    output logic [H_NUM_W-1:0] h_eff,
    output logic [V_NUM_W-1:0] v_eff,
    output expand_t            exp_eff
);

    localparam logic [H_NUM_W-1:0] H_CAP = H_NUM_W'(H_MAX);
    localparam logic [V_NUM_W-1:0] V_CAP = V_NUM_W'(V_MAX);

    logic [H_NUM_W-1:0] h_q, h_clamp;
    logic [V_NUM_W-1:0] v_q, v_clamp;
    expand_t            exp_q;

    assign h_clamp = (h_in > H_CAP) ? H_CAP : h_in;
    assign v_clamp = (v_in > V_CAP) ? V_CAP : v_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q        <= '0;
            v_q        <= '0;
            exp_q.hexp <= HEXP_X1;
            exp_q.vexp <= 1'b0;
        end else if (load) begin
            h_q   <= h_clamp;
            v_q   <= v_clamp;
            exp_q <= exp_in;
        end
    end

    // The field-start cycle already works with the new setting.
    assign h_eff   = load ? h_clamp : h_q;
    assign v_eff   = load ? v_clamp : v_q;
    assign exp_eff = load ? exp_in  : exp_q;

endmodule

// File: rtl/lrd_phase_acc.sv
module lrd_phase_acc
    import lrd_pkg::*;
#(
    parameter int unsigned NUM_W = H_NUM_BITS,
    parameter int unsigned DEN   = RATIO_DEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             step,
    input  logic [NUM_W-1:0] num,
    output logic             keep
);

    localparam int unsigned ACC_W = $clog2(DEN);
    localparam int unsigned SUM_W = ACC_W + 1;
    localparam logic [SUM_W-1:0] DEN_S = SUM_W'(DEN);

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] base;
    logic [SUM_W-1:0] sum;
    logic             wrap;

    assign base = restart ? '0 : acc;
    assign sum  = {1'b0, base} + SUM_W'(num);
    assign wrap = (sum >= DEN_S);
    assign keep = step && wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc <= '0;
        end else if (step) begin
            acc <= wrap ? ACC_W'(sum - DEN_S) : ACC_W'(sum);
        end else if (restart) begin
            acc <= '0;
        end
    end

endmodule

// File: rtl/lrd_rep_out.sv
module lrd_rep_out
    import lrd_pkg::*;
#(
    parameter int unsigned PIX_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                take,
    input  logic [PIX_W-1:0]    data,
    input  logic [REP_BITS-1:0] reps,
    output logic                out_valid,
    output logic [PIX_W-1:0]    out_data,
    output logic                in_ready
);

    logic [REP_BITS-1:0] left;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            left      <= '0;
        end else if (take) begin
            out_valid <= 1'b1;
            out_data  <= data;
            left      <= reps - 1'b1;
        end else if (left != '0) begin
            out_valid <= 1'b1;
            left      <= left - 1'b1;
        end else begin
            out_valid <= 1'b0;
        end
    end

    assign in_ready = (left == '0);

endmodule

// File: rtl/line_ratio_decimator.sv
module line_ratio_decimator
    import lrd_pkg::*;
#(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned H_NUM_W = H_NUM_BITS,
    parameter int unsigned V_NUM_W = V_NUM_BITS,
    parameter int unsigned H_MAX   = H_NUM_LIMIT,
    parameter int unsigned V_MAX   = V_NUM_LIMIT,
    parameter int unsigned DEN     = RATIO_DEN
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [H_NUM_W-1:0] hk_cfg,
    input  logic [V_NUM_W-1:0] vk_cfg,
    input  logic [1:0]         hexp_cfg,
    input  logic               vexp_cfg,
    input  logic               line_start,
    input  logic               field_start,
    input  logic               in_valid,
    input  logic [PIX_W-1:0]   in_data,
    output logic               in_ready,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_data,
    output logic               out_line_valid,
    output logic               out_line_rep
);

    logic               line_go;
    logic               accept;
    logic [H_NUM_W-1:0] h_num;
    logic [V_NUM_W-1:0] v_num;
    expand_t            exp_in, exp_eff;
    logic               v_keep, h_keep;
    logic               line_kept, line_rep, line_now, take;

    assign line_go     = line_start | field_start;
    assign exp_in.hexp = hexp_e'(hexp_cfg);
    assign exp_in.vexp = vexp_cfg;

    lrd_cfg_hold #(
        .H_NUM_W (H_NUM_W),
        .V_NUM_W (V_NUM_W),
        .H_MAX   (H_MAX),
        .V_MAX   (V_MAX)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .load    (field_start),
        .h_in    (hk_cfg),
        .v_in    (vk_cfg),
        .exp_in  (exp_in),
        .h_eff   (h_num),
        .v_eff   (v_num),
        .exp_eff (exp_eff)
    );

    lrd_phase_acc #(.NUM_W(V_NUM_W), .DEN(DEN)) u_vacc (
        .clk     (clk),
        .rst     (rst),
        .restart (field_start),
        .step    (line_go),
        .num     (v_num),
        .keep    (v_keep)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_kept <= 1'b0;
            line_rep  <= 1'b0;
        end else if (line_go) begin
            line_kept <= v_keep;
            line_rep  <= v_keep && exp_eff.vexp;
        end
    end

    assign accept   = in_valid && in_ready;
    assign line_now = line_go ? v_keep : line_kept;

    lrd_phase_acc #(.NUM_W(H_NUM_W), .DEN(DEN)) u_hacc (
        .clk     (clk),
        .rst     (rst),
        .restart (line_go),
        .step    (accept),
        .num     (h_num),
        .keep    (h_keep)
    );

    assign take = h_keep && line_now;

    lrd_rep_out #(.PIX_W(PIX_W)) u_out (
        .clk       (clk),
        .rst       (rst),
        .take      (take),
        .data      (in_data),
        .reps      (rep_count(exp_eff.hexp)),
        .out_valid (out_valid),
        .out_data  (out_data),
        .in_ready  (in_ready)
    );

    assign out_line_valid = line_kept;
    assign out_line_rep   = line_rep;

endmodule

// File: rtl/lrd_checker.sv
module lrd_checker #(
    parameter int unsigned PIX_W   = 8,
    parameter int unsigned H_NUM_W = 6,
    parameter int unsigned V_NUM_W = 7
) (
    input logic               clk,
    input logic               rst,
    input logic [H_NUM_W-1:0] hk_cfg,
    input logic [V_NUM_W-1:0] vk_cfg,
    input logic [1:0]         hexp_cfg,
    input logic               line_start,
    input logic               field_start,
    input logic               in_valid,
    input logic               in_ready,
    input logic               out_valid,
    input logic [PIX_W-1:0]   out_data,
    input logic               out_line_valid,
    input logic               out_line_rep
);

    logic       seen, off_q, off_now, prev_ready, prev_valid, fresh;
    logic [2:0] reps_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen       <= 1'b0;
            off_q      <= 1'b1;
            reps_q     <= 3'd1;
            prev_ready <= 1'b1;
            prev_valid <= 1'b0;
        end else begin
            prev_ready <= in_ready;
            prev_valid <= in_valid;
            if (field_start) begin
                seen   <= 1'b1;
                off_q  <= (hk_cfg == '0) || (vk_cfg == '0);
                reps_q <= (hexp_cfg == 2'b01) ? 3'd2 :
                          (hexp_cfg == 2'b11) ? 3'd4 : 3'd1;
            end
        end
    end

    assign off_now = field_start ? ((hk_cfg == '0) || (vk_cfg == '0)) : off_q;
    assign fresh   = out_valid && prev_ready;

    // R1
    no_early_out_chk: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (!out_valid && !out_line_valid));

    // R4
    window_off_chk: assert property (@(posedge clk) disable iff (rst)
        off_now |=> !(out_valid && prev_ready));

    // R7
    copy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_ready |=> (out_valid && $stable(out_data)));

    // R7
    copy_two_chk: assert property (@(posedge clk) disable iff (rst)
        (fresh && reps_q == 3'd2) |-> !in_ready ##1 in_ready);

    // R7
    copy_four_chk: assert property (@(posedge clk) disable iff (rst)
        (fresh && reps_q == 3'd4) |-> !in_ready ##1 !in_ready ##1 !in_ready ##1 in_ready);

    // R7
    copy_one_chk: assert property (@(posedge clk) disable iff (rst)
        (fresh && reps_q == 3'd1) |-> in_ready);

    // R8
    line_rep_chk: assert property (@(posedge clk) disable iff (rst)
        out_line_rep |-> out_line_valid);

    // R3
    line_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!line_start && !field_start) |=> $stable(out_line_valid));

    // R10
    pixel_cause_chk: assert property (@(posedge clk) disable iff (rst)
        fresh |-> prev_valid);

endmodule

bind line_ratio_decimator lrd_checker #(
    .PIX_W   (PIX_W),
    .H_NUM_W (H_NUM_W),
    .V_NUM_W (V_NUM_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .hk_cfg         (hk_cfg),
    .vk_cfg         (vk_cfg),
    .hexp_cfg       (hexp_cfg),
    .line_start     (line_start),
    .field_start    (field_start),
    .in_valid       (in_valid),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_data       (out_data),
    .out_line_valid (out_line_valid),
    .out_line_rep   (out_line_rep)
);

// File: tb/line_ratio_decimator_test.sv
module line_ratio_decimator_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] hk_cfg;
    logic [6:0] vk_cfg;
    logic [1:0] hexp_cfg;
    logic       vexp_cfg;
    logic       line_start, field_start, in_valid;
    logic [7:0] in_data;
    logic       in_ready, out_valid, out_line_valid, out_line_rep;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    line_ratio_decimator uut (
        .clk(clk), .rst(rst), .hk_cfg(hk_cfg), .vk_cfg(vk_cfg),
        .hexp_cfg(hexp_cfg), .vexp_cfg(vexp_cfg),
        .line_start(line_start), .field_start(field_start),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .out_valid(out_valid), .out_data(out_data),
        .out_line_valid(out_line_valid), .out_line_rep(out_line_rep)
    );

    int         checks = 0;
    int         fails  = 0;
    int         out_cnt = 0;
    int         dut_lines = 0;
    bit         done = 0;
    logic [7:0] exp_q[$];

    // Reference state, built from the requirements
    int m_hk = 0, m_vk = 0, m_reps = 1;
    bit m_vexp = 0, m_line = 0;
    int hacc = 0, vacc = 0;
    logic [7:0] pix = 8'd0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Monitor: pops expected pixels as the design produces them
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            out_cnt++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R10 unexpected pixel", int'(out_data), -1);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                check(out_data == e, "R10 pixel order/value", int'(out_data), int'(e));
            end
        end
    end

    task automatic run_line(input bit fs, input int n);
        int start_cnt;
        int expect_cnt;
        int sent;
        @(negedge clk);
        line_start  = 1'b1;
        field_start = fs;
        in_valid    = 1'b0;
        if (fs) begin
            m_hk   = (hk_cfg > 6'd48) ? 48 : int'(hk_cfg);
            m_vk   = (vk_cfg > 7'd96) ? 96 : int'(vk_cfg);
            m_reps = (hexp_cfg == 2'b01) ? 2 : (hexp_cfg == 2'b11) ? 4 : 1;
            m_vexp = vexp_cfg;
            vacc   = 0;
        end
        vacc += m_vk;
        if (vacc >= 96) begin vacc -= 96; m_line = 1'b1; end
        else m_line = 1'b0;
        hacc = 0;
        @(negedge clk);
        line_start  = 1'b0;
        field_start = 1'b0;
        check(out_line_valid == m_line, "R3 line kept flag", int'(out_line_valid), int'(m_line));
        check(out_line_rep == (m_line && m_vexp), "R8 line repeat flag",
              int'(out_line_rep), int'(m_line && m_vexp));
        if (out_line_valid) dut_lines++;
        start_cnt = out_cnt;
        sent = 0;
        while (sent < n) begin
            in_valid = 1'b1;
            in_data  = pix;
            if (in_ready) begin
                hacc += m_hk;
                if (hacc >= 96) begin
                    hacc -= 96;
                    if (m_line) for (int k = 0; k < m_reps; k++) exp_q.push_back(pix);
                end
                pix++;
                sent++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        expect_cnt = m_line ? ((n * m_hk) / 96) * m_reps : 0;
        // R2 / R7 count rule
        check(out_cnt - start_cnt == expect_cnt, "R2 R7 pixels per line",
              out_cnt - start_cnt, expect_cnt);
        check(exp_q.size() == 0, "R10 all expected pixels seen", exp_q.size(), 0);
    endtask

    task automatic run_field(input int nlines, input int npix);
        dut_lines = 0;
        for (int i = 0; i < nlines; i++) run_line(i == 0, npix);
        check(dut_lines == (nlines * m_vk) / 96, "R3 kept lines per field",
              dut_lines, (nlines * m_vk) / 96);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        hk_cfg = '0; vk_cfg = '0; hexp_cfg = 2'b00; vexp_cfg = 1'b0;
        line_start = 1'b0; field_start = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(out_line_valid == 1'b0, "R1 line flag after reset", int'(out_line_valid), 0);
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);

        // R1: a setting without a field start has no effect
        hk_cfg = 6'd48; vk_cfg = 7'd96;
        run_line(1'b0, 20);

        // R2: nominal line lengths
        run_field(1, 1408);
        hk_cfg = 6'd24; run_field(1, 1408);
        hk_cfg = 6'd1;  run_field(1, 1408);

        // R5: clamping of both numerators
        hk_cfg = 6'd60; vk_cfg = 7'd127; run_field(2, 1408);

        // R4: zero numerators switch the window off
        hk_cfg = 6'd0;  vk_cfg = 7'd96; run_field(2, 50);
        hk_cfg = 6'd48; vk_cfg = 7'd0;  run_field(2, 50);

        // R6: mid-field change ignored
        hk_cfg = 6'd24; vk_cfg = 7'd96; run_line(1'b1, 96);
        hk_cfg = 6'd48; run_line(1'b0, 96);

        // R7: copy codes 01, 11 and 10
        hk_cfg = 6'd48;
        hexp_cfg = 2'b01; run_field(1, 16);
        hexp_cfg = 2'b11; run_field(1, 16);
        hexp_cfg = 2'b10; run_field(1, 16);
        hexp_cfg = 2'b00;

        // R3 / R8: full-height fields with line doubling
        hk_cfg = 6'd48; vk_cfg = 7'd48; vexp_cfg = 1'b1; run_field(228, 4);
        vk_cfg = 7'd32; vexp_cfg = 1'b0; run_field(228, 4);

        // R9: phase restarts per line and per field
        hk_cfg = 6'd40; vk_cfg = 7'd40;
        run_field(3, 3);
        run_field(3, 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule